// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external serial master read and write a bank of up to thirty-two 8-bit registers. The master selects the block by pulling `cs_n` low and clocks bits in on `mosi` while the block answers on `miso`. Every transfer is two bytes long. The first byte carries a direction bit and a register address. The second byte carries either the value to store or the value being returned. The block never starts a transfer on its own.

The serial side is clocked only by `sclk`, in mode 0. The block samples on the rising edge and changes its output on the falling edge, and `sclk` rests low. The register bank sits in the `sys_clk` domain. It is reached through a one-cycle write strobe and an asynchronous read port, whose address comes from the first byte. A write is held back until the master releases `cs_n`. The release is then detected in the system domain and turned into one write strobe. The bank is never changed while a transfer is still running.

Top module: `spi_regport`

## Requirements
- R1: Bits are sampled on rising `sclk` edges, most significant bit first. In the first byte, bit 7 set means write and clear means read, bits 6 and 5 are ignored, and bits 4:0 hold the register address. The second byte is the data.
- R2: While selected, `miso` is 0 for the whole first byte.
- R3: On a read, the addressed register is loaded into the output shifter on the falling `sclk` edge that ends the eighth pulse. The second byte then appears on `miso` MSB first, each bit valid before the next rising edge.
- R4: `miso_oe` is high exactly while `cs_n` is low, so the line floats to the external pull-up when the block is deselected.
- R5: A complete write produces exactly one single-cycle `reg_wr_en` pulse carrying the first byte's address and the second byte's data. The pulse comes after `cs_n` rises, through a two-stage synchronizer, no earlier than the second rising `sys_clk` edge and no later than the third. No pulse appears while `cs_n` is low.
- R6: A write command whose transfer ends before all 16 bits have arrived is discarded and produces no pulse.
- R7: Addresses at or above `NUM_REGS` (24 by default) are not implemented. A read of one returns 0x00, and a write to one produces no pulse.
- R8: During the second byte of a write command, `miso` is 0.
- R9: The bit position restarts whenever `cs_n` goes high, so an aborted transfer leaves no trace in the next one.
- R10: Bits clocked after the sixteenth are ignored, and the write formed by the first two bytes is still committed.
- R11: After reset, `reg_wr_en` is low and `miso_oe` is low while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register-bank side |
| sys_rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` (tri-state control) |
| reg_wr_en | output | 1 | One-cycle register write strobe (sys_clk) |
| reg_wr_addr | output | 5 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 5 | Address driven to the asynchronous read port |
| reg_rd_data | input | 8 | Read data returned for `reg_rd_addr` |

## Verification
A wrong bit count shows up at once on the master's side: the returned byte arrives shifted, or `miso` leaves zero during the first byte. A wrong captured header or data byte only becomes visible when `cs_n` is released. It then appears as a strobe to the wrong register, a strobe that should be missing, or the wrong value when the register is read back in the next transfer. A broken completion toggle or synchronizer shows as a missing, doubled or early `reg_wr_en` pulse within a few `sys_clk` cycles of the release.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int DW    = 8;
  localparam int AW    = 5;
  localparam int FRAME = 2 * DW;
  localparam int CNTW  = $clog2(FRAME + 1);

  typedef logic [DW-1:0]   byte_t;
  typedef logic [AW-1:0]   addr_t;
  typedef logic [CNTW-1:0] cnt_t;

  localparam cnt_t HDR_LAST  = cnt_t'(DW - 1);
  localparam cnt_t DATA_LAST = cnt_t'(FRAME - 1);
  localparam cnt_t LOAD_AT   = cnt_t'(DW);
  localparam cnt_t CNT_MAX   = cnt_t'(FRAME);
endpackage

// File: rtl/spi_regport_rx.sv
module spi_regport_rx
  import spi_regport_pkg::*;
(
  input  logic  sclk,
  input  logic  xfer_rst_n,
  input  logic  hold_rst_n,
  input  logic  mosi,
  output cnt_t  bit_cnt_o,
  output logic  hdr_wr_o,
  output addr_t hdr_addr_o,
  output byte_t data_o,
  output logic  done_tgl_o
);
  cnt_t            cnt_q, cnt_d;
  logic [DW-2:0]   sh_q, sh_d;
  logic            hdr_wr_q;
  addr_t           hdr_addr_q;
  byte_t           data_q;
  logic            tgl_q;
  logic            hdr_en, data_en;

  always_comb begin
    cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + cnt_t'(1);
    sh_d    = {sh_q[DW-3:0], mosi};
    hdr_en  = (cnt_q == HDR_LAST);
    data_en = (cnt_q == DATA_LAST);
  end

  always_ff @(posedge sclk or negedge xfer_rst_n) begin
    if (!xfer_rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  always_ff @(posedge sclk or negedge hold_rst_n) begin
    if (!hold_rst_n) begin
      hdr_wr_q   <= 1'b0;
      hdr_addr_q <= '0;
      data_q     <= '0;
      tgl_q      <= 1'b0;
    end else begin
      if (hdr_en) begin
        hdr_wr_q   <= sh_q[DW-2];
        hdr_addr_q <= {sh_q[AW-2:0], mosi};
      end
      if (data_en) begin
        data_q <= {sh_q, mosi};
        tgl_q  <= ~tgl_q;
      end
    end
  end

  assign bit_cnt_o  = cnt_q;
  assign hdr_wr_o   = hdr_wr_q;
  assign hdr_addr_o = hdr_addr_q;
  assign data_o     = data_q;
  assign done_tgl_o = tgl_q;

  assert_cnt_saturates_R10: assert property (@(posedge sclk) disable iff (!xfer_rst_n)
    (cnt_q <= CNT_MAX));
  assert_toggle_on_full_frame_R6: assert property (@(posedge sclk) disable iff (!xfer_rst_n)
    (cnt_q == DATA_LAST) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx
  import spi_regport_pkg::*;
(
  input  logic  sclk,
  input  logic  xfer_rst_n,
  input  cnt_t  bit_cnt_i,
  input  logic  rd_ok_i,
  input  byte_t rd_data_i,
  output logic  miso_o
);
  byte_t tx_q, tx_d;
  byte_t launch;

  always_comb begin
    launch = rd_ok_i ? rd_data_i : '0;
    if (bit_cnt_i == LOAD_AT) begin
      tx_d = launch;
    end else if (bit_cnt_i > LOAD_AT) begin
      tx_d = {tx_q[DW-2:0], 1'b0};
    end else begin
      tx_d = tx_q;
    end
  end

  always_ff @(negedge sclk or negedge xfer_rst_n) begin
    if (!xfer_rst_n) tx_q <= '0;
    else             tx_q <= tx_d;
  end

  assign miso_o = tx_q[DW-1];

  assert_quiet_first_byte_R2: assert property (@(negedge sclk) disable iff (!xfer_rst_n)
    (bit_cnt_i < LOAD_AT) |-> (tx_q == '0));
endmodule

// File: rtl/spi_regport_commit.sv
module spi_regport_commit
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n_i,
  input  logic  done_tgl_i,
  input  logic  wr_cmd_i,
  input  logic  addr_ok_i,
  input  addr_t addr_i,
  input  byte_t data_i,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o
);
  logic [1:0] cs_sync_q;
  logic       cs_prev_q;
  logic       seen_q, seen_d;
  logic       wr_en_q, wr_en_d;
  addr_t      wr_addr_q;
  byte_t      wr_data_q;
  logic       release_evt, fresh;

  always_comb begin
    release_evt = cs_sync_q[1] & ~cs_prev_q;
    fresh       = release_evt & (done_tgl_i != seen_q);
    seen_d      = fresh ? done_tgl_i : seen_q;
    wr_en_d     = fresh & wr_cmd_i & addr_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync_q <= 2'b11;
      cs_prev_q <= 1'b1;
      seen_q    <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      cs_sync_q <= {cs_sync_q[0], cs_n_i};
      cs_prev_q <= cs_sync_q[1];
      seen_q    <= seen_d;
      wr_en_q   <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (wr_en_d) begin
      wr_addr_q <= addr_i;
      wr_data_q <= data_i;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q);
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (int'(wr_addr_q) < NUM_REGS));
  assert_wr_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> cs_prev_q);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          reg_wr_en,
  output logic [AW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [DW-1:0] reg_rd_data
);
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  logic       xfer_rst_n;
  cnt_t       bit_cnt;
  logic       hdr_wr;
  addr_t      hdr_addr;
  byte_t      data_byte;
  logic       done_tgl;
  logic       addr_ok;
  logic       rd_ok;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_pipe_q <= '0;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n     = rst_pipe_q[1];
  assign xfer_rst_n = sys_rst_n & ~cs_n;

  generate
    if (NUM_REGS >= (1 << AW)) begin : g_full_map
      assign addr_ok = 1'b1;
    end else begin : g_part_map
      assign addr_ok = (int'(hdr_addr) < NUM_REGS);
    end
  endgenerate

  assign rd_ok = ~hdr_wr & addr_ok;

  spi_regport_rx i_rx (
    .sclk       (sclk),
    .xfer_rst_n (xfer_rst_n),
    .hold_rst_n (sys_rst_n),
    .mosi       (mosi),
    .bit_cnt_o  (bit_cnt),
    .hdr_wr_o   (hdr_wr),
    .hdr_addr_o (hdr_addr),
    .data_o     (data_byte),
    .done_tgl_o (done_tgl)
  );

  spi_regport_tx i_tx (
    .sclk       (sclk),
    .xfer_rst_n (xfer_rst_n),
    .bit_cnt_i  (bit_cnt),
    .rd_ok_i    (rd_ok),
    .rd_data_i  (reg_rd_data),
    .miso_o     (miso)
  );

  spi_regport_commit #(.NUM_REGS(NUM_REGS)) i_commit (
    .clk        (sys_clk),
    .rst_n      (srst_n),
    .cs_n_i     (cs_n),
    .done_tgl_i (done_tgl),
    .wr_cmd_i   (hdr_wr),
    .addr_ok_i  (addr_ok),
    .addr_i     (hdr_addr),
    .data_i     (data_byte),
    .wr_en_o    (reg_wr_en),
    .wr_addr_o  (reg_wr_addr),
    .wr_data_o  (reg_wr_data)
  );

  assign miso_oe     = ~cs_n;
  assign reg_rd_addr = hdr_addr;

  assert_no_strobe_in_reset_R11: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !srst_n |-> !reg_wr_en);
endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int SYS_PERIOD = 10;
  localparam int SCK_HALF   = 20;
  localparam int NVEC       = 10;

  // vector: {first byte, second byte, bit count, expected second byte on miso, expect write}
  localparam logic [39:0] VECS [NVEC] = '{
    {8'h83, 8'hA5, 8'd16, 8'h00, 8'd1},  // R1 R8 write reg 3
    {8'h03, 8'h00, 8'd16, 8'hA5, 8'd0},  // R3 read back reg 3
    {8'h05, 8'h00, 8'd16, 8'h35, 8'd0},  // R3 read reg 5 preload
    {8'h85, 8'h5C, 8'd12, 8'h00, 8'd0},  // R6 short write
    {8'h05, 8'h00, 8'd16, 8'h35, 8'd0},  // R6 reg 5 untouched
    {8'h19, 8'h00, 8'd16, 8'h00, 8'd0},  // R7 read addr 25
    {8'h9A, 8'h77, 8'd16, 8'h00, 8'd0},  // R7 write addr 26
    {8'hE7, 8'h3C, 8'd20, 8'h00, 8'd1},  // R10 long write, bits 6:5 ignored
    {8'h47, 8'h00, 8'd16, 8'h3C, 8'd0},  // R1 read with bits 6:5 set
    {8'h17, 8'h00, 8'd16, 8'h47, 8'd0}   // R7 last implemented address
  };

  logic sys_clk = 1'b0;
  logic sys_rst_n, sclk, cs_n, mosi;
  logic miso, miso_oe, reg_wr_en;
  logic [4:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;

  logic [7:0] bank [32];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [4:0] last_addr;
  logic [7:0] last_data;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  spi_regport i_spi_regport (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .miso        (miso),
    .miso_oe     (miso_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data)
  );

  assign reg_rd_data = bank[reg_rd_addr];

  always @(negedge sys_clk) begin
    if (reg_wr_en) begin
      wr_cnt    = wr_cnt + 1;
      last_addr = reg_wr_addr;
      last_data = reg_wr_data;
      bank[reg_wr_addr] = reg_wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(posedge sys_clk);
    #(SYS_PERIOD/4);
  endtask

  task automatic xfer(input logic [7:0] b1, input logic [7:0] b2, input int nbits,
                      output logic [7:0] r1, output logic [7:0] r2, output logic oe_ok);
    r1 = '0; r2 = '0; oe_ok = 1'b1;
    cs_n = 1'b0;
    #SCK_HALF;
    for (int i = 0; i < nbits; i++) begin
      if (i < 8)       mosi = b1[7-i];
      else if (i < 16) mosi = b2[15-i];
      else             mosi = 1'b1;
      #SCK_HALF;
      if (!miso_oe) oe_ok = 1'b0;
      if (i < 8)       r1[7-i]  = miso;
      else if (i < 16) r2[15-i] = miso;
      sclk = 1'b1;
      #SCK_HALF;
      sclk = 1'b0;
    end
    #SCK_HALF;
  endtask

  task automatic run(input logic [7:0] b1, input logic [7:0] b2, input int nbits,
                     input logic [7:0] exp_rd, input bit exp_wr);
    logic [7:0] r1, r2;
    logic oe_ok;
    int base;
    base = wr_cnt;
    xfer(b1, b2, nbits, r1, r2, oe_ok);
    wait_sys(4);
    check(wr_cnt == base, "R5 no strobe while selected", wr_cnt - base, 0);
    check(oe_ok, "R4 miso_oe high while selected", oe_ok, 1);
    if (nbits >= 8)  check(r1 == 8'h00, "R2 first byte quiet", r1, 0);
    if (nbits >= 16) check(r2 == exp_rd, "R3 R7 R8 second byte on miso", r2, exp_rd);
    cs_n = 1'b1;
    mosi = 1'b0;
    #1;
    check(!miso_oe, "R4 miso_oe low when deselected", miso_oe, 0);
    wait_sys(1);
    check(wr_cnt == base, "R5 strobe not before synchronizer", wr_cnt - base, 0);
    wait_sys(6);
    check(wr_cnt - base == int'(exp_wr), "R5 R6 R7 R10 strobe count", wr_cnt - base, exp_wr);
    if (exp_wr) begin
      check(last_addr == b1[4:0], "R1 R5 write address", last_addr, b1[4:0]);
      check(last_data == b2, "R1 R5 write data", last_data, b2);
    end
  endtask

  initial begin
    #(SYS_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r1, r2;
    logic oe_ok;
    int base;
    for (int a = 0; a < 32; a++) bank[a] = 8'h30 + 8'(a);
    sys_rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    mosi = 1'b0;
    wait_sys(3);
    check(!reg_wr_en, "R11 no strobe in reset", reg_wr_en, 0);
    check(!miso_oe, "R11 miso_oe low in reset", miso_oe, 0);
    @(negedge sys_clk);
    sys_rst_n = 1'b1;
    wait_sys(6);
    check(wr_cnt == 0, "R11 no strobe after reset release", wr_cnt, 0);

    for (int k = 0; k < NVEC; k++) begin
      run(VECS[k][39:32], VECS[k][31:24], int'(VECS[k][23:16]), VECS[k][15:8], VECS[k][0]);
    end

    // R9: abort a write after five bits, then a fresh read must frame correctly
    base = wr_cnt;
    xfer(8'h83, 8'h11, 5, r1, r2, oe_ok);
    cs_n = 1'b1;
    wait_sys(8);
    check(wr_cnt == base, "R9 aborted transfer no strobe", wr_cnt - base, 0);
    run(8'h03, 8'h00, 16, 8'hA5, 1'b0);
    // R1: write to address 0 with an all-ones data byte, then read it back
    run(8'h80, 8'hFF, 16, 8'h00, 1'b1);
    run(8'h00, 8'h00, 16, 8'hFF, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule